// File: doc/BRIEF.md
# Multicart program bank-switching controller

This block sits on the cartridge side of an 8-bit console and remaps the CPU's upper 32 KB program window. The window is cut into four 8 KB slots, chosen by CPU address bits 14:13. Each slot holds an 8-bit page index. The program-ROM address is that page index followed by the low 13 CPU address bits. A single mirroring flag steers the nametable A10 line, so the picture side sees either horizontal or vertical nametable mirroring.

Software reprograms the slots by writing to one of four addresses, 0x8000 to 0x8003. The low two address bits pick how the slots are filled. Data bits 5:0 give a 16 KB bank number B, and data bit 7 swaps the even and odd page within each pair. Two of the four modes also load the mirroring flag from data bit 6. Writes to every other address change nothing.

Top module: `prg_bank_mapper`

## Requirements
- R1: After synchronous reset, slots 0, 1, 2 and 3 hold pages 0, 1, 2 and 3, and the mirroring is vertical (nt_a10 follows ppu_addr[10]).
- R2: A register write is a cycle with cpu_wr high and cpu_addr in 0x8000..0x8003. A cycle with cpu_wr low, or with any other address, leaves every slot and the mirroring unchanged.
- R3: A write at 0x8000 loads slots 0..3 with pages 2B, 2B+1, 2B+2 and 2B+3. When data bit 7 is set, it loads 2B+1, 2B, 2B+3 and 2B+2 instead.
- R4: A write at 0x8001 sets slot 2 to 2B and slot 3 to 2B+1, or the reverse when bit 7 is set. Slots 0 and 1 and the mirroring keep their values.
- R5: A write at 0x8002 loads all four slots with page 2B, or with page 2B+1 when bit 7 is set. The mirroring keeps its value.
- R6: A write at 0x8003 fills slots 2 and 3 as R4 does and keeps slots 0 and 1. It also loads the mirroring flag.
- R7: Writes at 0x8000 and 0x8003 select horizontal mirroring when data bit 6 is 1, so nt_a10 follows ppu_addr[11]. They select vertical mirroring when bit 6 is 0, so nt_a10 follows ppu_addr[10].
- R8: prg_addr equals {page of slot cpu_addr[14:13], cpu_addr[12:0]}, combinationally. A register write becomes visible in the cycle after its clock edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cpu_addr | input | 16 | CPU address |
| cpu_data | input | 8 | CPU write data |
| cpu_wr | input | 1 | CPU write strobe |
| ppu_addr | input | 14 | Picture-unit address |
| prg_addr | output | 21 | Program-ROM address |
| nt_a10 | output | 1 | Nametable A10 line |

## Verification
The hardest case to reach from the ports is a partial update. After a write at 0x8001 or 0x8003, slots 0 and 1 must still hold pages from an earlier, different write. This can only be seen through prg_addr with the address swept across all four slots. The stimulus therefore runs every data value in every mode one after another, so each partial write lands on a mapping left by a full-mode write with other data. Every slot and both nametable address bits are read back after each write and compared with a page model computed in the bench.

// File: rtl/prg_bank_mapper.sv
module prg_bank_mapper #(
  parameter int BANK_W = 6,
  localparam int PAGE_W = BANK_W + 2,
  localparam int OFFS_W = 13
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic [15:0]              cpu_addr,
  input  logic [7:0]               cpu_data,
  input  logic                     cpu_wr,
  input  logic [13:0]              ppu_addr,
  output logic [PAGE_W+OFFS_W-1:0] prg_addr,
  output logic                     nt_a10
);

  logic [PAGE_W-1:0] slot [4];
  logic              mirror_h;

  logic              hit;
  logic [1:0]        mode;
  logic [BANK_W:0]   b_lo, b_hi;
  logic              swap;

  assign hit  = cpu_wr && (cpu_addr[15:2] == 14'h2000);
  assign mode = cpu_addr[1:0];
  assign swap = cpu_data[7];
  assign b_lo = {1'b0, cpu_data[BANK_W-1:0]};
  assign b_hi = b_lo + 1'b1;

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < 4; i++) slot[i] <= PAGE_W'(i);
      mirror_h <= 1'b0;
    end else if (hit) begin
      case (mode)
        2'd0: begin
          slot[0]  <= {b_lo, swap};
          slot[1]  <= {b_lo, ~swap};
          slot[2]  <= {b_hi, swap};
          slot[3]  <= {b_hi, ~swap};
          mirror_h <= cpu_data[6];
        end
        2'd2: begin
          for (int i = 0; i < 4; i++) slot[i] <= {b_lo, swap};
        end
        default: begin
          slot[2] <= {b_lo, swap};
          slot[3] <= {b_lo, ~swap};
          if (mode == 2'd3) mirror_h <= cpu_data[6];
        end
      endcase
    end
  end

  assign prg_addr = {slot[cpu_addr[14:13]], cpu_addr[OFFS_W-1:0]};
  assign nt_a10   = mirror_h ? ppu_addr[11] : ppu_addr[10];

  localparam logic [PAGE_W-1:0] ONE = PAGE_W'(1);

  a_r2_ignored_write: assert property (@(posedge clk) disable iff (rst)
    !hit |=> $stable(slot[0]) && $stable(slot[1]) && $stable(slot[2])
             && $stable(slot[3]) && $stable(mirror_h));

  a_r3_pair_order: assert property (@(posedge clk) disable iff (rst)
    (hit && mode == 2'd0) |=> (slot[1] == (slot[0] ^ ONE)) && (slot[3] == (slot[2] ^ ONE))
      && (slot[2][PAGE_W-1:1] == (PAGE_W-1)'(slot[0][PAGE_W-1:1] + 1'b1)));

  a_r4_low_slots_kept: assert property (@(posedge clk) disable iff (rst)
    (hit && mode[0]) |=> $stable(slot[0]) && $stable(slot[1]) && (slot[3] == (slot[2] ^ ONE)));

  a_r5_uniform: assert property (@(posedge clk) disable iff (rst)
    (hit && mode == 2'd2) |=> (slot[0] == slot[1]) && (slot[1] == slot[2]) && (slot[2] == slot[3]));

  a_r7_mirror_kept: assert property (@(posedge clk) disable iff (rst)
    (hit && (mode[0] ^ mode[1])) |=> $stable(mirror_h));

endmodule

// File: tb/prg_bank_mapper_tb.sv
module prg_bank_mapper_tb;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [15:0] cpu_addr = 16'h0000;
  logic [7:0]  cpu_data = 8'h00;
  logic        cpu_wr = 1'b0;
  logic [13:0] ppu_addr = 14'h0000;
  logic [20:0] prg_addr;
  logic        nt_a10;

  int checks = 0;
  int fails = 0;
  int exp_slot [4];
  bit exp_h;

  always #(CLK_PERIOD/2) clk = ~clk;

  prg_bank_mapper u_dut (
    .clk(clk), .rst(rst), .cpu_addr(cpu_addr), .cpu_data(cpu_data),
    .cpu_wr(cpu_wr), .ppu_addr(ppu_addr), .prg_addr(prg_addr), .nt_a10(nt_a10)
  );

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic check_state(input string tag);
    for (int s = 0; s < 4; s++) begin
      int offs [3];
      offs[0] = 0; offs[1] = 'h1FFF; offs[2] = (s * 'h0A5B) & 'h1FFF;
      for (int k = 0; k < 3; k++) begin
        cpu_addr = 16'(32768 + s * 8192 + offs[k]);
        #1;
        check({tag, " R8 page"}, int'(prg_addr), exp_slot[s] * 8192 + offs[k]);
      end
    end
    ppu_addr = 14'h0800; #1;
    check({tag, " R7 mirror"}, int'(nt_a10), exp_h ? 1 : 0);
    ppu_addr = 14'h0400; #1;
    check({tag, " R7 mirror"}, int'(nt_a10), exp_h ? 0 : 1);
    ppu_addr = 14'h0000;
  endtask

  task automatic do_write(input logic [15:0] a, input logic [7:0] d, input bit strobe, input string tag);
    int b2;
    int sw;
    @(negedge clk);
    cpu_addr = a; cpu_data = d; cpu_wr = strobe;
    @(negedge clk);
    cpu_wr = 1'b0;
    b2 = 2 * int'(d & 8'h3F);
    sw = int'(d[7]);
    if (strobe && a >= 16'h8000 && a <= 16'h8003) begin
      case (a[1:0])
        2'd0: begin
          exp_slot[0] = b2 + sw;     exp_slot[1] = b2 + 1 - sw;
          exp_slot[2] = b2 + 2 + sw; exp_slot[3] = b2 + 3 - sw;
          exp_h = d[6];
        end
        2'd1: begin
          exp_slot[2] = b2 + sw; exp_slot[3] = b2 + 1 - sw;
        end
        2'd2: begin
          for (int i = 0; i < 4; i++) exp_slot[i] = b2 + sw;
        end
        default: begin
          exp_slot[2] = b2 + sw; exp_slot[3] = b2 + 1 - sw;
          exp_h = d[6];
        end
      endcase
    end
    check_state(tag);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    fails++;
    checks++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    for (int i = 0; i < 4; i++) exp_slot[i] = i;
    exp_h = 1'b0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    check_state("R1 reset");

    for (int m = 0; m < 4; m++) begin
      for (int d = 0; d < 256; d++) begin
        string tg;
        case (m)
          0: tg = "R3 mode0";
          1: tg = "R4 mode1";
          2: tg = "R5 mode2";
          default: tg = "R6 mode3";
        endcase
        do_write(16'(32768 + m), 8'(d), 1'b1, tg);
        if (m != 0 && (d % 37) == 0)
          do_write(16'h8000, 8'((d * 7 + 3) & 8'hFF), 1'b1, "R3 reload");
      end
    end

    do_write(16'h8000, 8'h45, 1'b1, "R3 setup");
    do_write(16'h8004, 8'hFF, 1'b1, "R2 addr 8004");
    do_write(16'h9000, 8'hC1, 1'b1, "R2 addr 9000");
    do_write(16'hC002, 8'h17, 1'b1, "R2 addr C002");
    do_write(16'hFFFF, 8'h80, 1'b1, "R2 addr FFFF");
    do_write(16'h7FFF, 8'h3A, 1'b1, "R2 addr 7FFF");
    do_write(16'h0000, 8'h3A, 1'b1, "R2 addr 0000");
    do_write(16'h0003, 8'h7F, 1'b1, "R2 addr 0003");
    do_write(16'h8000, 8'h3F, 1'b0, "R2 no strobe");
    do_write(16'h8003, 8'h00, 1'b0, "R2 no strobe");
    do_write(16'h8002, 8'hBF, 1'b1, "R5 max bank");
    do_write(16'h8000, 8'hFF, 1'b1, "R3 max bank");

    @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    for (int i = 0; i < 4; i++) exp_slot[i] = i;
    exp_h = 1'b0;
    check_state("R1 re-reset");

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule